// File: doc/BRIEF.md
# Sticky Lock Control Register Slice

This block is a two-register slice of a larger register bank. The first register is a 12-bit control word. It holds a 3-bit cryptographic mode enable field, a fault-mitigation enable, a secure-boot enable and a 7-bit debug enable field. The debug field packs five debug enables: four single-bit enables in bits [3:0] and a 3-bit access-port enable in bits [6:4]. The second register is a 4-bit lock word. Each lock bit can only be set. Once set, it freezes one group of control bits against further register writes.

Two resets act on the slice. The power-on reset is asynchronous and active low, and it clears both registers. The soft reset is synchronous and active high. It clears the control word but leaves the lock word untouched. After a soft reset under lock, the frozen control groups therefore stay at zero until the next power-on reset. This is how the debug lock keeps debug access from being switched back on. The current control bits are driven straight to output ports.

Top module: `sticky_lock_regs`

## Requirements
- R1: While power-on reset is asserted, and right after it, the control word, the lock word and every exported enable read as 0.
- R2: With no lock set, a write to the control offset (0) loads write data bits [11:0] into the control word. Write data bits above 11 are dropped.
- R3: A write to the lock offset (2) ORs write data bits [3:0] into the lock word. A 0 in any written bit never clears a lock bit.
- R4: Lock bit 0 freezes control bits [6:0], bit 1 freezes bit [7], bit 2 freezes bit [8] and bit 3 freezes bits [11:9]. In the same control write, the unfrozen bits still update.
- R5: A soft reset clears the control word to 0 at the next clock edge and leaves the lock word unchanged.
- R6: After a soft reset with lock bit 0 set, control writes cannot raise any debug enable in bits [6:0] until a power-on reset.
- R7: A power-on reset clears all lock bits, after which the formerly frozen control bits accept writes again.
- R8: Any write presented in a cycle where soft reset is high is ignored, whether it targets the control or the lock offset.
- R9: The read port returns, in the same cycle, the control word at offset 0 or the lock word at offset 2, zero-extended. Any other offset reads 0.
- R10: The exported enables equal the control word and change on the first clock edge after an accepted write or soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| softRst | input | 1 | Synchronous soft reset, active high |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W (4) | Write offset |
| wrData | input | DATA_W (32) | Write data |
| rdAddr | input | ADDR_W (4) | Read offset |
| rdData | output | DATA_W (32) | Read data, combinational |
| cryptoModeEn | output | 3 | Control bits [11:9] |
| faultMitEn | output | 1 | Control bit [8] |
| secureEn | output | 1 | Control bit [7] |
| dbgEn | output | 7 | Control bits [6:0] (five debug enables) |

## Verification
A write or a soft reset presented in one cycle shows in the registers and in the exported enables from the first rising edge after it. The read port is combinational, so a read result is due in the same cycle. Power-on reset acts immediately, without waiting for an edge. The bench changes inputs on falling edges and keeps a behavioural reference model that updates on rising edges. It compares the enables with the model at every falling edge, which is half a cycle after the edge that must have produced them. It checks directed read results one time step after the read offset is set.

// File: rtl/sticky_lock_pkg.sv
package sticky_lock_pkg;
  localparam int CTRL_W = 12;
  localparam int LOCK_W = 4;

  // Control bit span frozen by each lock bit (index = lock bit).
  localparam int GRP_LO [LOCK_W] = '{0, 7, 8, 9};
  localparam int GRP_HI [LOCK_W] = '{6, 7, 8, 11};

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_LOCK = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   ctrlWr;
    logic   lockWr;
    logic   ctrlClr;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/sticky_lock_ctl.sv
module sticky_lock_ctl
  import sticky_lock_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFS = 0,
  parameter int LOCK_OFS = 2
) (
  input  logic              softRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobes_t          strobes
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);

  logic wrAllowed;

  always_comb begin
    wrAllowed       = wrEn && !softRst;
    strobes.ctrlClr = softRst;
    strobes.ctrlWr  = wrAllowed && (wrAddr == CTRL_A);
    strobes.lockWr  = wrAllowed && (wrAddr == LOCK_A);
    if (rdAddr == CTRL_A)      strobes.rdSel = RD_CTRL;
    else if (rdAddr == LOCK_A) strobes.rdSel = RD_LOCK;
    else                       strobes.rdSel = RD_NONE;
  end
endmodule

// File: rtl/sticky_lock_dp.sv
module sticky_lock_dp
  import sticky_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic [LOCK_W-1:0] lockQ,
  output logic [DATA_W-1:0] rdData
);
  logic [CTRL_W-1:0] frozenMask;
  logic [CTRL_W-1:0] ctrlNext;
  logic [LOCK_W-1:0] lockNext;

  for (genvar k = 0; k < LOCK_W; k++) begin : g_mask
    localparam int SPAN = GRP_HI[k] - GRP_LO[k] + 1;
    assign frozenMask[GRP_HI[k]:GRP_LO[k]] = {SPAN{lockQ[k]}};
  end

  // The control update uses the lock word as it stood before this cycle.
  always_comb begin
    ctrlNext = ctrlQ;
    if (strobes.ctrlClr)
      ctrlNext = '0;
    else if (strobes.ctrlWr)
      ctrlNext = (ctrlQ & frozenMask) | (wrData[CTRL_W-1:0] & ~frozenMask);
  end

  always_comb begin
    lockNext = lockQ;
    if (strobes.lockWr)
      lockNext = lockQ | wrData[LOCK_W-1:0];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) ctrlQ <= '0;
    else          ctrlQ <= ctrlNext;
  end

  // Soft reset deliberately does not reach this register.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) lockQ <= '0;
    else          lockQ <= lockNext;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_CTRL: rdData = DATA_W'(ctrlQ);
      RD_LOCK: rdData = DATA_W'(lockQ);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/sticky_lock_regs.sv
module sticky_lock_regs
  import sticky_lock_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 0,
  parameter int LOCK_OFS = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        cryptoModeEn,
  output logic              faultMitEn,
  output logic              secureEn,
  output logic [6:0]        dbgEn
);
  strobes_t          strobes;
  logic [CTRL_W-1:0] ctrlQ;
  logic [LOCK_W-1:0] lockQ;

  sticky_lock_ctl #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .LOCK_OFS(LOCK_OFS)
  ) u_ctl (
    .softRst(softRst), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .strobes(strobes)
  );

  sticky_lock_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .porRstN(porRstN), .strobes(strobes), .wrData(wrData),
    .ctrlQ(ctrlQ), .lockQ(lockQ), .rdData(rdData)
  );

  assign cryptoModeEn = ctrlQ[11:9];
  assign faultMitEn   = ctrlQ[8];
  assign secureEn     = ctrlQ[7];
  assign dbgEn        = ctrlQ[6:0];
endmodule

// File: rtl/sticky_lock_chk.sv
module sticky_lock_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 0,
  parameter int LOCK_OFS = 2
) (
  input logic              clk,
  input logic              porRstN,
  input logic              softRst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [11:0]       ctrlBits,
  input logic [3:0]        lockBits
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);

  // R3: a lock bit never falls while power-on reset is released.
  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!porRstN)
    (($past(lockBits) & ~lockBits) == 4'b0));

  // R2: open write loads the low 12 bits.
  assert_open_write_R2: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && !softRst && wrAddr == CTRL_A && lockBits == 4'b0)
      |=> (ctrlBits == $past(wrData[11:0])));

  // R4: each frozen group holds unless soft reset clears it.
  assert_dbg_frozen_R4: assert property (@(posedge clk) disable iff (!porRstN)
    (lockBits[0] && !softRst) |=> (ctrlBits[6:0] == $past(ctrlBits[6:0])));
  assert_sec_frozen_R4: assert property (@(posedge clk) disable iff (!porRstN)
    (lockBits[1] && !softRst) |=> (ctrlBits[7] == $past(ctrlBits[7])));
  assert_fault_frozen_R4: assert property (@(posedge clk) disable iff (!porRstN)
    (lockBits[2] && !softRst) |=> (ctrlBits[8] == $past(ctrlBits[8])));
  assert_crypto_frozen_R4: assert property (@(posedge clk) disable iff (!porRstN)
    (lockBits[3] && !softRst) |=> (ctrlBits[11:9] == $past(ctrlBits[11:9])));

  // R5: soft reset clears control and keeps locks.
  assert_soft_clear_R5: assert property (@(posedge clk) disable iff (!porRstN)
    softRst |=> (ctrlBits == 12'b0));
  assert_soft_keeps_lock_R5: assert property (@(posedge clk) disable iff (!porRstN)
    softRst |=> (lockBits == $past(lockBits)));

  // R6: debug enables cannot rise while debug lock is set.
  assert_dbg_no_rise_R6: assert property (@(posedge clk) disable iff (!porRstN)
    lockBits[0] |=> ((ctrlBits[6:0] & ~$past(ctrlBits[6:0])) == 7'b0));

  // R9: unmapped offsets read zero.
  always_comb begin
    if (porRstN && rdAddr != CTRL_A && rdAddr != LOCK_A)
      assert_unmapped_zero_R9: assert (rdData == '0);
  end
endmodule

bind sticky_lock_regs sticky_lock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .LOCK_OFS(LOCK_OFS)
) u_chk (
  .clk(clk), .porRstN(porRstN), .softRst(softRst), .wrEn(wrEn),
  .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
  .ctrlBits(ctrlQ), .lockBits(lockQ)
);

// File: tb/sticky_lock_regs_test.sv
`timescale 1ns/1ps
module sticky_lock_regs_test;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        softRst = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [2:0]  cryptoModeEn;
  logic        faultMitEn, secureEn;
  logic [6:0]  dbgEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sticky_lock_regs uut (
    .clk(clk), .porRstN(porRstN), .softRst(softRst), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .cryptoModeEn(cryptoModeEn), .faultMitEn(faultMitEn),
    .secureEn(secureEn), .dbgEn(dbgEn)
  );

  // Behavioural reference model.
  int mCtrl = 0;
  int mLock = 0;

  function automatic bit frozen(int bitIdx, int lockWord);
    if (bitIdx <= 6)  return lockWord[0];
    if (bitIdx == 7)  return lockWord[1];
    if (bitIdx == 8)  return lockWord[2];
    return lockWord[3];
  endfunction

  always @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      mCtrl = 0;
      mLock = 0;
    end else if (softRst) begin
      mCtrl = 0;
    end else if (wrEn && wrAddr == 4'd0) begin
      for (int i = 0; i < 12; i++)
        if (!frozen(i, mLock)) mCtrl[i] = wrData[i];
    end else if (wrEn && wrAddr == 4'd2) begin
      mLock = mLock | int'(wrData[3:0]);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R10: enables compared with the model every cycle.
  always @(negedge clk) begin
    if (porRstN && !finished)
      check("R10 enables",
            {20'b0, cryptoModeEn, faultMitEn, secureEn, dbgEn},
            32'(mCtrl) & 32'hFFF);
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    rdAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic softPulse();
    @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
  endtask

  initial begin
    // R1: reset state while held and after release.
    repeat (2) @(negedge clk);
    rd("R1 ctrl in reset", 4'd0, 32'h0);
    rd("R1 lock in reset", 4'd2, 32'h0);
    check("R1 enables in reset", {25'b0, dbgEn}, 32'h0);
    porRstN = 1'b1;
    @(negedge clk);
    rd("R1 ctrl after reset", 4'd0, 32'h0);

    // R2: open writes, upper bits dropped.
    wr(4'd0, 32'hFFFF_FFFF);
    rd("R2 all ones", 4'd0, 32'h0000_0FFF);
    wr(4'd0, 32'h1234_50A5);
    rd("R2 pattern", 4'd0, 32'h0000_00A5);

    // R3/R4: debug lock then full write.
    wr(4'd2, 32'h1);
    rd("R3 lock0 set", 4'd2, 32'h1);
    wr(4'd0, 32'h0000_0FFF);
    rd("R4 dbg frozen others open", 4'd0, 32'h0000_0FA5);
    wr(4'd2, 32'h0);
    rd("R3 zero write keeps", 4'd2, 32'h1);
    wr(4'd2, 32'h4);
    rd("R3 accumulate", 4'd2, 32'h5);
    wr(4'd0, 32'h0);
    rd("R4 fault and dbg frozen", 4'd0, 32'h0000_0125);

    // R5: soft reset.
    softPulse();
    rd("R5 ctrl cleared", 4'd0, 32'h0);
    rd("R5 lock kept", 4'd2, 32'h5);

    // R6: debug stays off under lock after soft reset.
    wr(4'd0, 32'h0000_0FFF);
    rd("R6 dbg held at zero", 4'd0, 32'h0000_0E80);
    check("R6 dbgEn port", {25'b0, dbgEn}, 32'h0);

    // R8: writes during soft reset ignored.
    @(negedge clk);
    softRst = 1'b1; wrEn = 1'b1; wrAddr = 4'd2; wrData = 32'h8;
    @(negedge clk);
    softRst = 1'b0; wrEn = 1'b0;
    rd("R8 lock write ignored", 4'd2, 32'h5);
    @(negedge clk);
    softRst = 1'b1; wrEn = 1'b1; wrAddr = 4'd0; wrData = 32'hFFF;
    @(negedge clk);
    softRst = 1'b0; wrEn = 1'b0;
    rd("R8 ctrl write ignored", 4'd0, 32'h0);

    // R9: unmapped offsets.
    rd("R9 offset 1", 4'd1, 32'h0);
    rd("R9 offset 15", 4'd15, 32'h0);

    // R4: every group frozen.
    wr(4'd2, 32'hFFFF_FFFA);
    rd("R9 lock zero-extended", 4'd2, 32'hF);
    wr(4'd0, 32'h0000_0FFF);
    rd("R4 all frozen", 4'd0, 32'h0);

    // R7: power-on reset clears locks.
    @(negedge clk);
    porRstN = 1'b0;
    #1;
    rd("R7 lock cleared", 4'd2, 32'h0);
    @(negedge clk);
    porRstN = 1'b1;
    wr(4'd0, 32'h0000_007F);
    rd("R7 dbg writable again", 4'd0, 32'h0000_007F);
    check("R7 dbgEn port", {25'b0, dbgEn}, 32'h7F);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule